// File: doc/BRIEF.md
# Paired-Compare PWM Generator

This block is an up-counting timer that joins two compare channels, one even and one odd, to produce a single pulse-width-modulated pin. The counter starts each period from a programmable initial count and runs up to a programmable modulo. The even compare value places one edge of the pulse and the odd compare value places the other. Both edges can therefore sit anywhere inside the period, which supports phase-shifted and asymmetric waveforms.

Each channel has a match flag that is set by its own compare event and is cleared by a software strobe. Each flag has an interrupt enable that gates it onto an interrupt request line. The paired mode is active only for one combination of four mode bits. With any other combination the counter keeps running, but the pulse state and the flags freeze. Two polarity bits choose a high-true pulse, a low-true pulse, or a pin held low. The odd channel's polarity bits are accepted and ignored.

Top module: `pair_pwm`

## Requirements
- R1: Pulse updates and flag sets happen only while ext_en=1, dcap_en=0, pair_en=1 and center_en=0. With any other combination, the pulse state and the pin hold, and the flags only keep or clear.
- R2: On every clock with tick_en=1, the counter loads init_val if it is greater than or equal to mod_val, and otherwise adds one. It resets to 0. With init_val<=mod_val the period is mod_val-init_val+1 ticks.
- R3: With pol_b=1 and pol_a=0, the clock edge on which the counter holds init_val drives pwm_out low. The edge on which it holds cmp_even drives it high, and the edge on which it holds cmp_odd drives it low.
- R4: With pol_a=1 (pol_b either value), the same three events drive pwm_out high, low and high respectively.
- R5: With pol_b=0 and pol_a=0, pwm_out is 0.
- R6: When several of the three events fall on the same tick, the event later in the order period-start, even match, odd match decides the pulse level.
- R7: With init_val<=cmp_even<cmp_odd<=mod_val, pwm_out sits at its active level for exactly cmp_odd-cmp_even ticks of each period.
- R8: A compare match sets its flag on the next edge. The flag stays set until its clear strobe is 1 on a clock edge. A match on the same tick as the clear leaves the flag set.
- R9: irq_even is 1 exactly when flag_even and ie_even are both 1. irq_odd is 1 exactly when flag_odd and ie_odd are both 1.
- R10: odd_pol has no effect on any output.
- R11: While rst_n is low, the flags and interrupts are 0 and the pulse state is inactive. pwm_out then shows the inactive level for the current polarity bits. The internal reset is released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter clock enable |
| ext_en | input | 1 | Extended-feature enable (must be 1) |
| dcap_en | input | 1 | Dual-edge capture enable (must be 0) |
| pair_en | input | 1 | Channel pairing enable (must be 1) |
| center_en | input | 1 | Center-aligned counting select (must be 0) |
| pol_b | input | 1 | Polarity select, upper bit |
| pol_a | input | 1 | Polarity select, lower bit |
| odd_pol | input | 2 | Odd channel polarity bits (ignored) |
| init_val | input | W | Counter initial value |
| mod_val | input | W | Counter modulo value |
| cmp_even | input | W | Even channel compare value |
| cmp_odd | input | W | Odd channel compare value |
| ie_even | input | 1 | Even channel interrupt enable |
| ie_odd | input | 1 | Odd channel interrupt enable |
| clr_even | input | 1 | Even flag clear strobe |
| clr_odd | input | 1 | Odd flag clear strobe |
| pwm_out | output | 1 | PWM pin |
| flag_even | output | 1 | Even channel match flag |
| flag_odd | output | 1 | Odd channel match flag |
| irq_even | output | 1 | Even channel interrupt request |
| irq_odd | output | 1 | Odd channel interrupt request |

## Verification
A wrong counter value shows at the ports within one period. A flag then rises on the wrong tick, or the interval between two flag rises differs from mod_val-init_val+1. A wrong pulse state or a wrong event priority flips pwm_out on the very next tick at which the bench compares it with its arithmetic model. A missed or extra flag update shows on the edge after the match, and a sweep over every compare pair of two small periods counts the active ticks against cmp_odd-cmp_even.

// File: rtl/pair_pwm_pkg.sv
package pair_pwm_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned N_REF     = 3;
  localparam int unsigned N_CH      = 2;

  // bit order is the priority order: later bits win
  typedef struct packed {
    logic odd;
    logic even;
    logic start;
  } hit_t;

  function automatic logic pin_level(logic pb, logic pa, logic pulse);
    return (pb | pa) & (pulse ^ pa);
  endfunction
endpackage

// File: rtl/ppwm_counter.sv
module ppwm_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] mod_val,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (cnt_q >= mod_val) cnt_d = init_val;
    else                  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppwm_compare.sv
module ppwm_compare #(
  parameter int unsigned W = 16
) (
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] ref_val,
  output logic         hit
);
  assign hit = en & (cnt == ref_val);
endmodule

// File: rtl/ppwm_flag.sv
module ppwm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag_q,
  output logic irq
);
  logic flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q & ie;
endmodule

// File: rtl/ppwm_outgen.sv
module ppwm_outgen
  import pair_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  hit_t hits,
  input  logic pol_b,
  input  logic pol_a,
  output logic pulse_q,
  output logic pin
);
  logic pulse_d;
  logic upd;

  always_comb begin
    upd     = hits.start | hits.even | hits.odd;
    pulse_d = pulse_q;
    if (hits.start) pulse_d = 1'b0;
    if (hits.even)  pulse_d = 1'b1;
    if (hits.odd)   pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pulse_q <= 1'b0;
    else if (upd) pulse_q <= pulse_d;
  end

  assign pin = pin_level(pol_b, pol_a, pulse_q);
endmodule

// File: rtl/pair_pwm.sv
module pair_pwm
  import pair_pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         ext_en,
  input  logic         dcap_en,
  input  logic         pair_en,
  input  logic         center_en,
  input  logic         pol_b,
  input  logic         pol_a,
  input  logic [1:0]   odd_pol,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] mod_val,
  input  logic [W-1:0] cmp_even,
  input  logic [W-1:0] cmp_odd,
  input  logic         ie_even,
  input  logic         ie_odd,
  input  logic         clr_even,
  input  logic         clr_odd,
  output logic         pwm_out,
  output logic         flag_even,
  output logic         flag_odd,
  output logic         irq_even,
  output logic         irq_odd
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_ns;
  logic                  active;
  logic                  fire;
  logic [W-1:0]          cnt_q;
  logic [W-1:0]          ref_val [N_REF];
  logic [N_REF-1:0]      hit_vec;
  hit_t                  hits;
  logic [N_CH-1:0]       ch_set, ch_clr, ch_ie, ch_flag, ch_irq;
  logic                  pulse_q;
  logic                  unused_odd_pol;

  // reset: asserted asynchronously, released after RST_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rst_pipe[RST_STAGES-1];

  assign unused_odd_pol = ^odd_pol;

  assign active = ext_en & ~dcap_en & pair_en & ~center_en;
  assign fire   = tick_en & active;

  ppwm_counter #(.W(W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .tick_en  (tick_en),
    .init_val (init_val),
    .mod_val  (mod_val),
    .cnt_q    (cnt_q)
  );

  assign ref_val[0] = init_val;
  assign ref_val[1] = cmp_even;
  assign ref_val[2] = cmp_odd;

  for (genvar g = 0; g < N_REF; g++) begin : g_cmp
    ppwm_compare #(.W(W)) i_cmp (
      .en      (fire),
      .cnt     (cnt_q),
      .ref_val (ref_val[g]),
      .hit     (hit_vec[g])
    );
  end
  assign hits = hit_t'(hit_vec);

  assign ch_set = {hits.odd, hits.even};
  assign ch_clr = {clr_odd, clr_even};
  assign ch_ie  = {ie_odd, ie_even};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ppwm_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_ns),
      .set    (ch_set[c]),
      .clr    (ch_clr[c]),
      .ie     (ch_ie[c]),
      .flag_q (ch_flag[c]),
      .irq    (ch_irq[c])
    );
  end

  assign flag_even = ch_flag[0];
  assign flag_odd  = ch_flag[1];
  assign irq_even  = ch_irq[0];
  assign irq_odd   = ch_irq[1];

  ppwm_outgen i_out (
    .clk     (clk),
    .rst_n   (rst_ns),
    .hits    (hits),
    .pol_b   (pol_b),
    .pol_a   (pol_a),
    .pulse_q (pulse_q),
    .pin     (pwm_out)
  );
endmodule

// File: rtl/pair_pwm_chk.sv
module pair_pwm_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ns,
  input logic         tick_en,
  input logic         active,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] init_val,
  input logic [W-1:0] mod_val,
  input logic [W-1:0] cmp_even,
  input logic [W-1:0] cmp_odd,
  input logic         pulse_q,
  input logic         pwm_out,
  input logic         pol_a,
  input logic         pol_b,
  input logic         flag_even,
  input logic         flag_odd,
  input logic         clr_odd,
  input logic         ie_even,
  input logic         irq_even
);
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    tick_en && (cnt_q >= mod_val) |=> cnt_q == $past(init_val));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    tick_en && (cnt_q < mod_val) |=> cnt_q == $past(cnt_q) + W'(1));

  assert_freeze_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    !(tick_en && active) |=> pulse_q == $past(pulse_q));

  assert_even_edge_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    tick_en && active && (cnt_q == cmp_even) && (cnt_q != cmp_odd) |=> pulse_q);

  assert_odd_wins_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    tick_en && active && (cnt_q == cmp_odd) |=> !pulse_q);

  assert_match_wins_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    tick_en && active && (cnt_q == cmp_even) |=> flag_even);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    flag_odd && !clr_odd |=> flag_odd);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !(flag_even && ie_even) |-> !irq_even);

  assert_pin_off_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    !pol_a && !pol_b |-> !pwm_out);
endmodule

bind pair_pwm pair_pwm_chk #(.W(W)) i_pair_pwm_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .tick_en   (tick_en),
  .active    (active),
  .cnt_q     (cnt_q),
  .init_val  (init_val),
  .mod_val   (mod_val),
  .cmp_even  (cmp_even),
  .cmp_odd   (cmp_odd),
  .pulse_q   (pulse_q),
  .pwm_out   (pwm_out),
  .pol_a     (pol_a),
  .pol_b     (pol_b),
  .flag_even (flag_even),
  .flag_odd  (flag_odd),
  .clr_odd   (clr_odd),
  .ie_even   (ie_even),
  .irq_even  (irq_even)
);

// File: tb/test_pair_pwm.sv
module test_pair_pwm;
  localparam int  W          = 16;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, tick_en, ext_en, dcap_en, pair_en, center_en, pol_b, pol_a;
  logic [1:0] odd_pol;
  logic [W-1:0] init_val, mod_val, cmp_even, cmp_odd;
  logic ie_even, ie_odd, clr_even, clr_odd;
  logic pwm_out, flag_even, flag_odd, irq_even, irq_odd;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_cnt;
  logic m_pulse, m_fe, m_fo;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_pwm #(.W(W)) i_pair_pwm (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_en(ext_en),
    .dcap_en(dcap_en), .pair_en(pair_en), .center_en(center_en),
    .pol_b(pol_b), .pol_a(pol_a), .odd_pol(odd_pol),
    .init_val(init_val), .mod_val(mod_val), .cmp_even(cmp_even), .cmp_odd(cmp_odd),
    .ie_even(ie_even), .ie_odd(ie_odd), .clr_even(clr_even), .clr_odd(clr_odd),
    .pwm_out(pwm_out), .flag_even(flag_even), .flag_odd(flag_odd),
    .irq_even(irq_even), .irq_odd(irq_odd)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_pin(logic pulse);
    return (pol_b | pol_a) & (pulse ^ pol_a);
  endfunction

  function automatic string pin_tag();
    if (pol_a) return "R4";
    if (pol_b) return "R3";
    return "R5";
  endfunction

  task automatic set_cfg(input int iv, input int mv, input int ev, input int ov);
    init_val = W'(iv); mod_val = W'(mv); cmp_even = W'(ev); cmp_odd = W'(ov);
  endtask

  task automatic do_reset();
    tick_en = 1'b0; clr_even = 1'b0; clr_odd = 1'b0;
    rst_n = 1'b0;
    #1;
    check(pwm_out == exp_pin(1'b0), "R11", "pwm_out in reset", pwm_out, exp_pin(1'b0));
    check(flag_even == 1'b0 && flag_odd == 1'b0, "R11", "flags in reset",
          {flag_even, flag_odd}, 0);
    check(irq_even == 1'b0 && irq_odd == 1'b0, "R11", "irqs in reset",
          {irq_even, irq_odd}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) begin @(posedge clk); #1; end
    m_cnt = '0; m_pulse = 1'b0; m_fe = 1'b0; m_fo = 1'b0;
  endtask

  // one clock: model next state from the requirements, then compare
  task automatic step(input string tag);
    logic act_m;
    logic [W-1:0] n_cnt;
    logic n_p, n_fe, n_fo, se, so;
    string tp, tf, ti;
    act_m = ext_en & ~dcap_en & pair_en & ~center_en;
    n_cnt = m_cnt; n_p = m_pulse; se = 1'b0; so = 1'b0;
    if (tick_en) begin
      n_cnt = (m_cnt >= mod_val) ? init_val : m_cnt + W'(1);
      if (act_m) begin
        if (m_cnt == init_val) n_p = 1'b0;
        if (m_cnt == cmp_even) begin n_p = 1'b1; se = 1'b1; end
        if (m_cnt == cmp_odd)  begin n_p = 1'b0; so = 1'b1; end
      end
    end
    n_fe = se | (m_fe & ~clr_even);
    n_fo = so | (m_fo & ~clr_odd);
    @(posedge clk); #1;
    m_cnt = n_cnt; m_pulse = n_p; m_fe = n_fe; m_fo = n_fo;
    tp = (tag == "") ? pin_tag() : tag;
    tf = (tag == "") ? "R8" : tag;
    ti = (tag == "") ? "R9" : tag;
    check(pwm_out == exp_pin(m_pulse), tp, "pwm_out", pwm_out, exp_pin(m_pulse));
    check(flag_even == m_fe, tf, "flag_even", flag_even, m_fe);
    check(flag_odd == m_fo, tf, "flag_odd", flag_odd, m_fo);
    check(irq_even == (m_fe & ie_even), ti, "irq_even", irq_even, m_fe & ie_even);
    check(irq_odd == (m_fo & ie_odd), ti, "irq_odd", irq_odd, m_fo & ie_odd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int win, acc, last_hit, gap;
    bit done, lvl, start_now;
    rst_n = 1'b0; tick_en = 1'b0;
    ext_en = 1'b1; dcap_en = 1'b0; pair_en = 1'b1; center_en = 1'b0;
    pol_b = 1'b1; pol_a = 1'b0; odd_pol = 2'b00;
    ie_even = 1'b1; ie_odd = 1'b1; clr_even = 1'b0; clr_odd = 1'b0;
    set_cfg(0, 3, 1, 2);
    #1;

    // sweep: every compare pair, two initial counts, two periods, three polarities
    for (int pm = 0; pm < 3; pm++) begin
      for (int ii = 0; ii < 2; ii++) begin
        for (int pp = 0; pp < 2; pp++) begin
          for (int e = 0; e < 6; e++) begin
            for (int o = 0; o < 6; o++) begin
              int iv, pr;
              iv = ii * 3;
              pr = (pp == 1) ? 6 : 4;
              if (e < pr && o < pr) begin
                {pol_b, pol_a} = (pm == 0) ? 2'b10 : (pm == 1) ? 2'b01 : 2'b11;
                set_cfg(iv, iv + pr - 1, iv + e, iv + o);
                odd_pol = 2'(e + o);
                ie_even = e[0]; ie_odd = o[0];
                do_reset();
                tick_en = 1'b1;
                lvl = ~pol_a;
                win = 0; acc = 0; done = 1'b0;
                for (int t = 0; t < iv + 2 * pr + 2; t++) begin
                  clr_even = (t % 5 == 4);
                  clr_odd  = (t % 3 == 2);
                  start_now = (m_cnt == init_val);
                  if (start_now && !done && win == 0) begin win = pr; acc = 0; end
                  step("");
                  if (win > 0) begin
                    if (pwm_out == lvl) acc++;
                    win--;
                    if (win == 0) begin
                      done = 1'b1;
                      if (e < o) check(acc == o - e, "R7", "active ticks per period", acc, o - e);
                    end
                  end
                end
              end
            end
          end
        end
      end
    end

    // R1: each disabling mode bit freezes pulse and flag sets
    for (int k = 0; k < 4; k++) begin
      {pol_b, pol_a} = 2'b10; odd_pol = 2'b00;
      ext_en = 1'b1; dcap_en = 1'b0; pair_en = 1'b1; center_en = 1'b0;
      set_cfg(0, 5, 1, 3);
      do_reset();
      tick_en = 1'b1; clr_even = 1'b0; clr_odd = 1'b0;
      for (int t = 0; t < 3; t++) step("R1");
      case (k)
        0: ext_en = 1'b0;
        1: dcap_en = 1'b1;
        2: pair_en = 1'b0;
        default: center_en = 1'b1;
      endcase
      for (int t = 0; t < 14; t++) begin
        clr_even = (t == 4); clr_odd = (t == 4);
        step("R1");
      end
    end
    ext_en = 1'b1; dcap_en = 1'b0; pair_en = 1'b1; center_en = 1'b0;

    // R2: gated ticks, then modulo lowered below the running count
    set_cfg(2, 9, 4, 7);
    do_reset();
    for (int t = 0; t < 30; t++) begin
      tick_en = (t % 3 != 1);
      clr_even = (t % 4 == 0); clr_odd = (t % 4 == 0);
      step("R2");
    end
    tick_en = 1'b1;
    set_cfg(2, 3, 2, 3);
    for (int t = 0; t < 16; t++) step("R2");

    // R2: spacing of flag sets equals the period
    set_cfg(1, 6, 3, 5);
    do_reset();
    tick_en = 1'b1; clr_even = 1'b1; clr_odd = 1'b1;
    last_hit = -1; gap = 0;
    for (int t = 0; t < 24; t++) begin
      step("R2");
      if (flag_even) begin
        if (last_hit >= 0) gap = t - last_hit;
        last_hit = t;
      end
    end
    check(gap == 6, "R2", "ticks between even matches", gap, 6);
    clr_even = 1'b0; clr_odd = 1'b0;

    // R6: coincident events
    for (int k = 0; k < 3; k++) begin
      {pol_b, pol_a} = 2'b10;
      case (k)
        0: set_cfg(0, 4, 0, 2);
        1: set_cfg(0, 4, 2, 2);
        default: set_cfg(0, 4, 0, 0);
      endcase
      do_reset();
      tick_en = 1'b1;
      for (int t = 0; t < 12; t++) step("R6");
    end

    // R10: odd channel polarity bits change every tick
    {pol_b, pol_a} = 2'b10;
    set_cfg(0, 5, 1, 4);
    do_reset();
    tick_en = 1'b1;
    for (int t = 0; t < 24; t++) begin
      odd_pol = 2'(t);
      step("R10");
    end

    // R5: pin off
    {pol_b, pol_a} = 2'b00;
    do_reset();
    tick_en = 1'b1;
    for (int t = 0; t < 12; t++) step("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule